// File: doc/BRIEF.md
# Two-Mode Audio Frame Sequencer

This block paces the slow update units of a sound generator. It counts processor clock cycles and sends two single-cycle strobes at fixed points in a repeating sequence. The quarter strobe drives the envelope and linear-counter units. The half strobe drives the length-counter and sweep units. The steps are `STEP` cycles apart by default, and that spacing is a parameter (default 7457).

A control write sets two things: the sequence mode and an interrupt-inhibit bit. The write also restarts the sequence.

- **Mode 0** has four equal steps. The fourth step raises a frame interrupt flag and wraps the sequence.
- **Mode 1** fires its first step in the cycle the write takes effect. Its last gap is two steps long, so one lap takes 1.25 times as long as a mode-0 lap. Mode 1 never raises the flag.

A status read returns the flag and clears it. Power-on reset restarts everything. A warm reset input leaves the sequence, the mode and the inhibit bit untouched, so masking the interrupt after a warm reset is left to the processor.

Top module: `afs_frame_seq`

## Requirements
- R1: While `cold_rst_n` is low, `qtr_pulse`, `half_pulse`, `irq` and `rd_flag` are 0, and mode and inhibit are 0. After release, the block runs the mode-0 sequence counted from the release: the first step is seen STEP clock edges after release.
- R2: After a write with `wr_mode`=0 is captured at edge W, steps appear after edges W+STEP, W+2·STEP, W+3·STEP and W+4·STEP, and then repeat every 4·STEP cycles.
- R3: After a write with `wr_mode`=1 is captured at edge W, steps appear after edges W, W+STEP, W+2·STEP and W+3·STEP, and then repeat with a lap of 5·STEP cycles.
- R4: Every step drives `qtr_pulse` high for exactly one cycle. `half_pulse` is high in that same cycle only for the second and fourth steps of a lap.
- R5: In mode 0, with inhibit clear, the fourth step sets the frame interrupt flag. The flag is seen on `irq` and stays high until it is cleared.
- R6: Mode 1 never sets the frame interrupt flag.
- R7: `rd_flag` shows the flag. A cycle with `rd_en`=1 clears the flag at that edge, unless a flag-setting step falls on the same edge, in which case the flag stays set.
- R8: A write with `wr_irq_inhibit`=1 clears a pending flag at once, and the flag stays clear while inhibit remains 1.
- R9: If mode-0 writes repeat at intervals shorter than 4·STEP cycles, the fourth step never occurs and `irq` never rises.
- R10: `warm_rst` has no effect on step timing, on the mode, on the inhibit bit or on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| cold_rst_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst | input | 1 | Warm reset request; has no effect on this block |
| wr_en | input | 1 | Control write strobe; restarts the sequence |
| wr_mode | input | 1 | Mode written with the strobe (0: four equal steps, 1: five-step lap) |
| wr_irq_inhibit | input | 1 | Inhibit bit written with the strobe (1: flag cleared and blocked) |
| rd_en | input | 1 | Status read strobe; clears the flag |
| rd_flag | output | 1 | Frame interrupt flag as seen by a status read |
| qtr_pulse | output | 1 | Quarter strobe: envelope and linear counter |
| half_pulse | output | 1 | Half strobe: length counter and sweep |
| irq | output | 1 | Level interrupt request |

## Verification
Every output is registered. A strobe, a flag change or a read clear is therefore due in the cycle that follows the capturing edge. The step at offset 0 of a mode-1 write is due in the cycle right after the write edge. The bench drives inputs at the falling edge and samples at the next falling edge. It keeps an offset count from the last restart and derives the expected strobe pattern and flag from that offset and the requirements, checking every cycle. The same-edge read-and-set case, rewrites at 4·STEP−3 cycles, and a warm reset held across a step are all placed at exact offsets.

// File: rtl/afs_pkg.sv
package afs_pkg;

  typedef enum logic [2:0] {
    STEP_NONE,
    STEP_ONE,
    STEP_TWO,
    STEP_THREE,
    STEP_FOUR
  } step_e;

  // Even steps clock the half-frame units too
  function automatic logic step_is_half(step_e s);
    return (s == STEP_TWO) || (s == STEP_FOUR);
  endfunction

  // Cycle offset of the idx-th mark from a restart
  function automatic int unsigned step_mark(int unsigned idx, int unsigned spacing);
    return idx * spacing;
  endfunction

endpackage

// File: rtl/afs_cycle_counter.sv
module afs_cycle_counter #(
  parameter int STEP  = 7457,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             cold_rst_n,
  input  logic             restart,
  input  logic             wrap,
  output logic [CNT_W-1:0] nxt_cnt
);
  localparam logic [CNT_W-1:0] LAP_MAX = CNT_W'(afs_pkg::step_mark(5, STEP));

  logic [CNT_W-1:0] cnt_q;

  assign nxt_cnt = restart ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) cnt_q <= '0;
    else if (wrap)   cnt_q <= '0;
    else             cnt_q <= nxt_cnt;
  end

  a_r2_restart_zero: assert property (@(posedge clk) disable iff (!cold_rst_n)
    restart |=> (cnt_q == '0));

  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!cold_rst_n)
    cnt_q < LAP_MAX);

endmodule

// File: rtl/afs_step_decode.sv
module afs_step_decode #(
  parameter int STEP  = 7457,
  parameter int CNT_W = 16
) (
  input  logic              [CNT_W-1:0] nxt_cnt,
  input  logic                          mode,
  output afs_pkg::step_e                step,
  output logic                          wrap
);
  import afs_pkg::*;

  localparam int NMARK = 6;

  logic [NMARK-1:0] hit;

  for (genvar i = 0; i < NMARK; i++) begin : g_mark
    localparam logic [CNT_W-1:0] MK = CNT_W'(step_mark(i, STEP));
    assign hit[i] = (nxt_cnt == MK);
  end

  always_comb begin
    step = STEP_NONE;
    wrap = 1'b0;
    if (!mode) begin
      if      (hit[1]) step = STEP_ONE;
      else if (hit[2]) step = STEP_TWO;
      else if (hit[3]) step = STEP_THREE;
      else if (hit[4]) begin
        step = STEP_FOUR;
        wrap = 1'b1;
      end
    end else begin
      if (hit[0] || hit[5]) begin
        step = STEP_ONE;
        wrap = hit[5];
      end
      else if (hit[1]) step = STEP_TWO;
      else if (hit[2]) step = STEP_THREE;
      else if (hit[3]) step = STEP_FOUR;
    end
  end

endmodule

// File: rtl/afs_irq_flag.sv
module afs_irq_flag (
  input  logic clk,
  input  logic cold_rst_n,
  input  logic set_evt,
  input  logic rd_clr,
  input  logic inh_clr,
  output logic flag
);
  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n)           flag <= 1'b0;
    else if (set_evt)          flag <= 1'b1;
    else if (rd_clr || inh_clr) flag <= 1'b0;
  end

  a_r5_set_raises: assert property (@(posedge clk) disable iff (!cold_rst_n)
    set_evt |=> flag);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (rd_clr && !set_evt) |=> !flag);

  a_r7_holds_idle: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (!rd_clr && !inh_clr && !set_evt) |=> $stable(flag));

endmodule

// File: rtl/afs_frame_seq.sv
module afs_frame_seq #(
  parameter int STEP  = 7457,
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic cold_rst_n,
  input  logic warm_rst,
  input  logic wr_en,
  input  logic wr_mode,
  input  logic wr_irq_inhibit,
  input  logic rd_en,
  output logic rd_flag,
  output logic qtr_pulse,
  output logic half_pulse,
  output logic irq
);
  import afs_pkg::*;

  logic             mode_q, inhib_q;
  logic             mode_eff, inhib_eff;
  logic [CNT_W-1:0] nxt_cnt;
  logic             wrap;
  step_e            step;
  logic             frame_set;
  logic             flag;

  // A write takes effect on its own edge
  assign mode_eff  = wr_en ? wr_mode        : mode_q;
  assign inhib_eff = wr_en ? wr_irq_inhibit : inhib_q;

  afs_cycle_counter #(.STEP(STEP), .CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .restart    (wr_en),
    .wrap       (wrap),
    .nxt_cnt    (nxt_cnt)
  );

  afs_step_decode #(.STEP(STEP), .CNT_W(CNT_W)) u_dec (
    .nxt_cnt (nxt_cnt),
    .mode    (mode_eff),
    .step    (step),
    .wrap    (wrap)
  );

  assign frame_set = (step == STEP_FOUR) && !mode_eff && !inhib_eff;

  afs_irq_flag u_irq (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .set_evt    (frame_set),
    .rd_clr     (rd_en),
    .inh_clr    (wr_en && wr_irq_inhibit),
    .flag       (flag)
  );

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      mode_q     <= 1'b0;
      inhib_q    <= 1'b0;
      qtr_pulse  <= 1'b0;
      half_pulse <= 1'b0;
    end else begin
      if (wr_en) begin
        mode_q  <= wr_mode;
        inhib_q <= wr_irq_inhibit;
      end
      qtr_pulse  <= (step != STEP_NONE);
      half_pulse <= step_is_half(step);
    end
  end

  assign rd_flag = flag;
  assign irq     = flag;

  a_r4_half_with_qtr: assert property (@(posedge clk) disable iff (!cold_rst_n)
    half_pulse |-> qtr_pulse);

  a_r4_qtr_single: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (qtr_pulse && !wr_en) |=> !qtr_pulse);

  a_r6_mode1_quiet: assert property (@(posedge clk) disable iff (!cold_rst_n)
    $rose(irq) |-> !mode_q);

  a_r8_inhibit_quiet: assert property (@(posedge clk) disable iff (!cold_rst_n)
    inhib_q |-> !irq);

  a_r10_warm_keeps_cfg: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (warm_rst && !wr_en) |=> ($stable(mode_q) && $stable(inhib_q)));

endmodule

// File: tb/afs_frame_seq_test.sv
module afs_frame_seq_test;
  localparam int S = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic cold_rst_n = 1'b0, warm_rst = 1'b0, wr_en = 1'b0;
  logic wr_mode = 1'b0, wr_irq_inhibit = 1'b0, rd_en = 1'b0;
  logic rd_flag, qtr_pulse, half_pulse, irq;

  int checks = 0, fails = 0, off = 0;
  bit cur_mode = 0, cur_inh = 0, exp_irq = 0, done = 0;

  afs_frame_seq #(.STEP(S), .CNT_W(16)) uut (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst(warm_rst), .wr_en(wr_en),
    .wr_mode(wr_mode), .wr_irq_inhibit(wr_irq_inhibit), .rd_en(rd_en),
    .rd_flag(rd_flag), .qtr_pulse(qtr_pulse), .half_pulse(half_pulse), .irq(irq)
  );

  // Expected {quarter, half} at a cycle offset from the last restart
  function automatic logic [1:0] exp_qh(bit m, int o);
    int p;
    if (!m) begin
      if (o > 0 && o % S == 0) return {1'b1, logic'((o / S) % 2 == 0)};
      return 2'b00;
    end
    p = o % (5 * S);
    if (p == 0 || p == 2 * S) return 2'b10;
    if (p == S || p == 3 * S) return 2'b11;
    return 2'b00;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    logic [1:0] e;
    e = exp_qh(cur_mode, off);
    check(qtr_pulse === e[1], req, $sformatf("qtr_pulse at offset %0d", off), int'(qtr_pulse), int'(e[1]));
    check(half_pulse === e[0], req, $sformatf("half_pulse at offset %0d", off), int'(half_pulse), int'(e[0]));
    check(irq === exp_irq, req, $sformatf("irq at offset %0d", off), int'(irq), int'(exp_irq));
  endtask

  task automatic tick(string req, bit rd = 0, bit wm = 0);
    rd_en = rd;
    warm_rst = wm;
    @(negedge clk);
    rd_en = 0;
    warm_rst = 0;
    off++;
    if (rd) exp_irq = 0;
    if (!cur_mode && !cur_inh && off % (4 * S) == 0) exp_irq = 1;
    compare(req);
  endtask

  task automatic run(int n, string req);
    for (int i = 0; i < n; i++) tick(req);
  endtask

  task automatic write_cfg(bit m, bit inh, string req);
    wr_en = 1; wr_mode = m; wr_irq_inhibit = inh;
    @(negedge clk);
    wr_en = 0; wr_mode = 0; wr_irq_inhibit = 0;
    off = 0; cur_mode = m; cur_inh = inh;
    if (inh) exp_irq = 0;
    compare(req);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(qtr_pulse === 0, "R1", "qtr_pulse in reset", int'(qtr_pulse), 0);
    check(half_pulse === 0, "R1", "half_pulse in reset", int'(half_pulse), 0);
    check(irq === 0, "R1", "irq in reset", int'(irq), 0);
    check(rd_flag === 0, "R1", "rd_flag in reset", int'(rd_flag), 0);
    cold_rst_n = 1;
    off = 0; cur_mode = 0; cur_inh = 0; exp_irq = 0;
    run(4 * S + 3, "R1");
    check(irq === 1, "R5", "irq after first lap", int'(irq), 1);
  endtask

  task automatic t_mode0;
    write_cfg(0, 0, "R2");
    check(rd_flag === 1, "R7", "rd_flag before read", int'(rd_flag), 1);
    tick("R7", 1);
    check(irq === 0, "R7", "irq after read", int'(irq), 0);
    run(4 * S - 1 - off, "R2");
    tick("R7", 1);  // read on the flag-setting edge
    check(irq === 1, "R7", "set wins over read", int'(irq), 1);
    run(4 * S + 2, "R4");
    tick("R7", 1);
    check(rd_flag === 0, "R7", "rd_flag after read", int'(rd_flag), 0);
  endtask

  task automatic t_mode1;
    write_cfg(1, 0, "R3");
    check(qtr_pulse === 1, "R3", "step on write cycle", int'(qtr_pulse), 1);
    run(11 * S, "R3");
    check(irq === 0, "R6", "irq in mode 1", int'(irq), 0);
  endtask

  task automatic t_rewrite;
    for (int k = 0; k < 6; k++) begin
      write_cfg(0, 0, "R9");
      run(4 * S - 3, "R9");
    end
    check(irq === 0, "R9", "irq with frequent rewrites", int'(irq), 0);
  endtask

  task automatic t_inhibit;
    write_cfg(0, 0, "R8");
    run(4 * S, "R8");
    check(irq === 1, "R8", "flag pending before inhibit", int'(irq), 1);
    write_cfg(0, 1, "R8");
    check(irq === 0, "R8", "inhibit clears flag", int'(irq), 0);
    run(9 * S, "R8");
    check(rd_flag === 0, "R8", "flag blocked by inhibit", int'(rd_flag), 0);
  endtask

  task automatic t_warm;
    write_cfg(0, 0, "R10");
    run(2 * S - 3, "R10");
    for (int i = 0; i < S + 5; i++) tick("R10", 0, 1);
    run(4 * S + 2 - off, "R10");
    check(irq === 1, "R10", "flag set through warm reset", int'(irq), 1);
    write_cfg(1, 1, "R10");
    for (int i = 0; i < 4; i++) tick("R10", 0, 1);
    run(6 * S, "R10");
    check(irq === 0, "R10", "inhibit kept through warm reset", int'(irq), 0);
  endtask

  initial begin
    t_reset;
    t_mode0;
    t_mode1;
    t_rewrite;
    t_inhibit;
    t_warm;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule